// File: doc/BRIEF.md
# Vector Floating-Point Add/Subtract Decoder

This block sits in the decode stage of a vector unit. It looks at one 32-bit instruction word together with the active vector configuration: the element-width code and the register grouping factor, given as a base-2 logarithm. It decides whether the word is one of the single-width floating-point add, subtract or reverse-subtract instructions. If it is, the block also reports whether the operands are legal under the vector rules. The decode logic is combinational. Its result is captured in one register stage that is enabled by an input strobe, and a one-cycle valid pulse goes with it.

Two operand forms exist. In the vector-vector form both sources are vector register groups. In the vector-scalar form the first source field names a floating-point scalar register. The block reports the operation, the form, the three register fields and the mask bit. It also raises a flag when the element width has no floating-point type, when a register group is misaligned, or when a masked destination would overwrite the mask register v0. Raising the exception and carrying out the arithmetic belong to later stages.

Top module: `vfas_decoder`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `out_valid`, `out_hit`, `out_op`, `out_scalar`, `out_unmasked`, `out_vd`, `out_vs2`, `out_src1` and `out_illegal` are all 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high. The other outputs change only on an edge where `in_valid` is high, and hold their value otherwise.
- R3: A word is recognised (`out_hit`=1) exactly when three conditions all hold. Bits 6:0 equal 1010111. Bits 14:12 equal 001 (vector-vector form) or 101 (vector-scalar form). Bits 31:26 equal 000000 or 000010 in either form, or 100111 in the vector-scalar form only.
- R4: On a hit, `out_op` is 01 for add (000000), 10 for subtract (000010) and 11 for reverse subtract (100111). `out_scalar` is 1 exactly for the vector-scalar form.
- R5: On a hit, `out_vd` carries bits 11:7, `out_vs2` carries bits 24:20, `out_src1` carries bits 19:15, and `out_unmasked` carries bit 25 (1 = all elements active, 0 = masked by v0).
- R6: On a hit, element-width code 0 (8-bit) sets `out_illegal`. Codes 1, 2 and 3 (16-, 32- and 64-bit floats) do not set it on their own.
- R7: On a hit with bit 25 = 0, `out_illegal` is set when the destination group contains v0, that is when vd < 2^`cfg_grp_log2`.
- R8: On a hit, `out_illegal` is set when vd or vs2 is not a multiple of 2^`cfg_grp_log2`. In the vector-vector form the same test applies to the bits 19:15 field; in the vector-scalar form that field is never tested.
- R9: When a word is not recognised, every output except `out_valid` is 0, including `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Strobe: capture the decode of `in_instr` |
| in_instr | input | 32 | Instruction word |
| cfg_ew | input | 2 | Element-width code (0:8, 1:16, 2:32, 3:64 bits) |
| cfg_grp_log2 | input | 2 | Log2 of the register grouping factor (1, 2, 4, 8) |
| out_valid | output | 1 | One-cycle pulse after a strobe |
| out_hit | output | 1 | Word is in the add/subtract group |
| out_op | output | 2 | 01 add, 10 subtract, 11 reverse subtract, 00 none |
| out_scalar | output | 1 | Vector-scalar form |
| out_unmasked | output | 1 | Bit 25 of the word |
| out_vd | output | 5 | Destination register |
| out_vs2 | output | 5 | Second vector source |
| out_src1 | output | 5 | First source: vector or FP scalar register |
| out_illegal | output | 1 | Operands break a vector legality rule |

## Verification
The bench uses the default configuration of five-bit register indices and two-bit width and grouping codes. This configuration is small enough to sweep exhaustively in the dimensions that carry the legality rules. The sweep covers every element-width code, every grouping factor, both mask settings, all 32 destination indices and the five valid operation/form pairs. Eight source pairs are chosen to hit each alignment boundary. Every combination of the two function fields is also swept, together with a wrong major opcode, so that the recognition boundary and the all-zero result for unrecognised words are covered completely.

// File: rtl/vfas_pkg.sv
package vfas_pkg;

  parameter int unsigned INSTR_W = 32;
  parameter int unsigned REG_W   = 5;
  parameter int unsigned EW_W    = 2;
  parameter int unsigned GRP_W   = 2;
  parameter int unsigned MAJ_W   = 7;
  parameter int unsigned F3_W    = 3;
  parameter int unsigned F6_W    = 6;

  // field positions inside the instruction word
  localparam int unsigned MAJ_LSB  = 0;
  localparam int unsigned VD_LSB   = 7;
  localparam int unsigned F3_LSB   = 12;
  localparam int unsigned SRC1_LSB = 15;
  localparam int unsigned VS2_LSB  = 20;
  localparam int unsigned VM_BIT   = 25;
  localparam int unsigned F6_LSB   = 26;

  localparam logic [MAJ_W-1:0] MAJ_VECTOR = 7'b1010111;
  localparam logic [F3_W-1:0]  F3_VV      = 3'b001;
  localparam logic [F3_W-1:0]  F3_VF      = 3'b101;
  localparam logic [F6_W-1:0]  F6_ADD     = 6'b000000;
  localparam logic [F6_W-1:0]  F6_SUB     = 6'b000010;
  localparam logic [F6_W-1:0]  F6_RSUB    = 6'b100111;

  typedef enum logic [1:0] {
    VFAS_NONE = 2'd0,
    VFAS_ADD  = 2'd1,
    VFAS_SUB  = 2'd2,
    VFAS_RSUB = 2'd3
  } vfas_op_e;

  typedef struct packed {
    logic [F6_W-1:0]  f6;
    logic             unmasked;
    logic [REG_W-1:0] vs2;
    logic [REG_W-1:0] src1;
    logic [F3_W-1:0]  f3;
    logic [REG_W-1:0] vd;
    logic [MAJ_W-1:0] major;
  } vfas_fields_t;

  typedef struct packed {
    logic             hit;
    vfas_op_e         op;
    logic             scalar;
    logic             unmasked;
    logic [REG_W-1:0] vd;
    logic [REG_W-1:0] vs2;
    logic [REG_W-1:0] src1;
    logic             illegal;
  } vfas_result_t;

endpackage

// File: rtl/vfas_rst_sync.sv
module vfas_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/vfas_field_split.sv
module vfas_field_split
  import vfas_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output vfas_fields_t       fields
);

  always_comb begin
    fields.major    = instr[MAJ_LSB  +: MAJ_W];
    fields.vd       = instr[VD_LSB   +: REG_W];
    fields.f3       = instr[F3_LSB   +: F3_W];
    fields.src1     = instr[SRC1_LSB +: REG_W];
    fields.vs2      = instr[VS2_LSB  +: REG_W];
    fields.unmasked = instr[VM_BIT];
    fields.f6       = instr[F6_LSB   +: F6_W];
  end

endmodule

// File: rtl/vfas_op_match.sv
module vfas_op_match
  import vfas_pkg::*;
(
  input  vfas_fields_t fields,
  output logic         hit,
  output vfas_op_e     op,
  output logic         scalar
);

  always_comb begin
    hit    = 1'b0;
    op     = VFAS_NONE;
    scalar = 1'b0;
    if (fields.major == MAJ_VECTOR) begin
      unique case (fields.f3)
        F3_VV: begin
          unique case (fields.f6)
            F6_ADD: begin hit = 1'b1; op = VFAS_ADD; end
            F6_SUB: begin hit = 1'b1; op = VFAS_SUB; end
            default: ;
          endcase
        end
        F3_VF: begin
          unique case (fields.f6)
            F6_ADD:  begin hit = 1'b1; op = VFAS_ADD;  scalar = 1'b1; end
            F6_SUB:  begin hit = 1'b1; op = VFAS_SUB;  scalar = 1'b1; end
            F6_RSUB: begin hit = 1'b1; op = VFAS_RSUB; scalar = 1'b1; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vfas_legal_check.sv
module vfas_legal_check
  import vfas_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned GW = GRP_W,
  parameter int unsigned EW = EW_W
) (
  input  logic [EW-1:0] ew,
  input  logic [GW-1:0] grp_log2,
  input  logic [RW-1:0] vd,
  input  logic [RW-1:0] vs2,
  input  logic [RW-1:0] src1,
  input  logic          unmasked,
  input  logic          scalar,
  output logic          ew_bad,
  output logic          overlap_bad,
  output logic          align_bad
);

  localparam int unsigned NOPS = 3;

  logic [RW-1:0]            grp_mask;
  logic [NOPS-1:0][RW-1:0]  idx;
  logic [NOPS-1:0]          checked;
  logic [NOPS-1:0]          misaligned;

  // low bits that must be zero for an index aligned to the group
  assign grp_mask = (RW'(1) << grp_log2) - RW'(1);

  // operand slots: 0 = vd, 1 = vs2, 2 = first source
  assign idx     = {src1, vs2, vd};
  assign checked = {~scalar, 1'b1, 1'b1};

  for (genvar k = 0; k < NOPS; k++) begin : g_align
    assign misaligned[k] = checked[k] & (|(idx[k] & grp_mask));
  end

  assign align_bad   = |misaligned;
  // destination group starts inside the first group, which holds v0
  assign overlap_bad = ~unmasked & ~(|(vd & ~grp_mask));
  assign ew_bad      = (ew == '0);

endmodule

// File: rtl/vfas_decoder.sv
module vfas_decoder
  import vfas_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [EW_W-1:0]    cfg_ew,
  input  logic [GRP_W-1:0]   cfg_grp_log2,
  output logic               out_valid,
  output logic               out_hit,
  output logic [1:0]         out_op,
  output logic               out_scalar,
  output logic               out_unmasked,
  output logic [REG_W-1:0]   out_vd,
  output logic [REG_W-1:0]   out_vs2,
  output logic [REG_W-1:0]   out_src1,
  output logic               out_illegal
);

  logic         rst_sync_n;
  vfas_fields_t fields;
  logic         hit;
  vfas_op_e     op;
  logic         scalar;
  logic         ew_bad;
  logic         overlap_bad;
  logic         align_bad;

  vfas_result_t res_d;
  vfas_result_t res_q;
  logic         valid_d;
  logic         valid_q;

  vfas_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vfas_field_split i_split (
    .instr  (in_instr),
    .fields (fields)
  );

  vfas_op_match i_match (
    .fields (fields),
    .hit    (hit),
    .op     (op),
    .scalar (scalar)
  );

  vfas_legal_check #(
    .RW (REG_W),
    .GW (GRP_W),
    .EW (EW_W)
  ) i_legal (
    .ew          (cfg_ew),
    .grp_log2    (cfg_grp_log2),
    .vd          (fields.vd),
    .vs2         (fields.vs2),
    .src1        (fields.src1),
    .unmasked    (fields.unmasked),
    .scalar      (scalar),
    .ew_bad      (ew_bad),
    .overlap_bad (overlap_bad),
    .align_bad   (align_bad)
  );

  // next state
  always_comb begin
    res_d   = '0;
    valid_d = in_valid;
    if (hit) begin
      res_d.hit      = 1'b1;
      res_d.op       = op;
      res_d.scalar   = scalar;
      res_d.unmasked = fields.unmasked;
      res_d.vd       = fields.vd;
      res_d.vs2      = fields.vs2;
      res_d.src1     = fields.src1;
      res_d.illegal  = ew_bad | overlap_bad | align_bad;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
    end else if (in_valid) begin
      res_q <= res_d;
    end
  end

  assign out_valid    = valid_q;
  assign out_hit      = res_q.hit;
  assign out_op       = res_q.op;
  assign out_scalar   = res_q.scalar;
  assign out_unmasked = res_q.unmasked;
  assign out_vd       = res_q.vd;
  assign out_vs2      = res_q.vs2;
  assign out_src1     = res_q.src1;
  assign out_illegal  = res_q.illegal;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_hit) && $stable(out_op) && $stable(out_vd) && $stable(out_illegal))); // R2
  AST_EW_ZERO_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && hit && ew_bad) |=> out_illegal); // R6
  AST_ILLEGAL_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_illegal |-> out_hit); // R9
  AST_RSUB_SCALAR_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_hit && out_op == VFAS_RSUB) |-> out_scalar); // R4

endmodule

// File: tb/test_vfas_decoder.sv
module test_vfas_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [1:0]  cfg_ew = '0;
  logic [1:0]  cfg_grp_log2 = '0;
  logic        out_valid, out_hit, out_scalar, out_unmasked, out_illegal;
  logic [1:0]  out_op;
  logic [4:0]  out_vd, out_vs2, out_src1;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  vfas_decoder i_vfas_decoder (
    .clk, .rst_n, .in_valid, .in_instr, .cfg_ew, .cfg_grp_log2,
    .out_valid, .out_hit, .out_op, .out_scalar, .out_unmasked,
    .out_vd, .out_vs2, .out_src1, .out_illegal
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int f6, input int vm, input int vs2,
                                      input int s1, input int f3, input int vd);
    return {f6[5:0], vm[0], vs2[4:0], s1[4:0], f3[2:0], vd[4:0], 7'b1010111};
  endfunction

  // apply one word, capture and compare against the model
  task automatic apply(input logic [31:0] w, input int ew, input int glog);
    int f6, f3, vm, vd, vs2, s1, gsz;
    bit recog, scl, ill;
    int op;
    @(negedge clk);
    in_instr = w; cfg_ew = ew[1:0]; cfg_grp_log2 = glog[1:0]; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    f6 = int'(w[31:26]); f3 = int'(w[14:12]); vm = int'(w[25]);
    vd = int'(w[11:7]); vs2 = int'(w[24:20]); s1 = int'(w[19:15]);
    recog = (w[6:0] == 7'b1010111) &&
            ((f3 == 1 && (f6 == 0 || f6 == 2)) ||
             (f3 == 5 && (f6 == 0 || f6 == 2 || f6 == 39)));
    scl = recog && f3 == 5;
    op  = !recog ? 0 : (f6 == 0 ? 1 : (f6 == 2 ? 2 : 3));
    gsz = 1 << glog;
    ill = recog && (ew == 0 || (vm == 0 && vd < gsz) || (vd % gsz) != 0 ||
                    (vs2 % gsz) != 0 || (!scl && (s1 % gsz) != 0));
    check("R2", "valid pulse", int'(out_valid), 1);
    check("R3", "hit", int'(out_hit), int'(recog));
    if (recog) begin
      check("R4", "op", int'(out_op), op);
      check("R4", "scalar form", int'(out_scalar), int'(scl));
      check("R5", "vd", int'(out_vd), vd);
      check("R5", "vs2", int'(out_vs2), vs2);
      check("R5", "src1", int'(out_src1), s1);
      check("R5", "mask bit", int'(out_unmasked), vm);
      check("R6,R7,R8", "illegal", int'(out_illegal), int'(ill));
    end else begin
      check("R9", "fields zero", int'({out_op, out_scalar, out_unmasked, out_vd,
                                       out_vs2, out_src1, out_illegal}), 0);
    end
  endtask

  function automatic int pair_vs2(input int k);
    case (k)
      0: return 0;  1: return 1;  2: return 2;  3: return 4;
      4: return 6;  5: return 8;  6: return 12; default: return 16;
    endcase
  endfunction

  function automatic int pair_s1(input int k);
    case (k)
      0: return 8;  1: return 3;  2: return 4;  3: return 16;
      4: return 2;  5: return 24; 6: return 31; default: return 0;
    endcase
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [4:0] held_vd;
    // R1: reset state while reset is low
    #(CLK_PERIOD*2 + 1);
    check("R1", "valid in reset", int'(out_valid), 0);
    check("R1", "outputs in reset", int'({out_hit, out_op, out_scalar, out_unmasked,
                                          out_vd, out_vs2, out_src1, out_illegal}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "valid after release", int'(out_valid), 0);
    check("R1", "outputs after release", int'({out_hit, out_op, out_scalar, out_unmasked,
                                               out_vd, out_vs2, out_src1, out_illegal}), 0);

    // directed corners
    apply(enc(39, 1, 4, 3, 5, 8), 2, 2);   // R4 rsub scalar form, odd scalar index ignored (R8)
    apply(enc(39, 1, 4, 4, 1, 8), 2, 2);   // R3 rsub pattern in vector-vector form is not recognised
    apply(enc(0, 1, 8, 8, 1, 8), 0, 0);    // R6 element width code 0
    apply(enc(0, 0, 8, 8, 1, 0), 1, 0);    // R7 masked destination v0
    apply(enc(2, 0, 8, 8, 1, 4), 1, 3);    // R7 masked destination inside first group of 8
    apply(enc(2, 0, 8, 8, 1, 8), 1, 3);    // R7 masked destination at 8 is legal
    apply(enc(0, 1, 8, 3, 1, 8), 3, 1);    // R8 vector-vector source misaligned

    // R2: idle cycle holds outputs and drops valid
    held_vd = out_vd;
    @(negedge clk);
    in_instr = enc(2, 1, 1, 1, 1, 17);
    @(negedge clk);
    check("R2", "valid idle", int'(out_valid), 0);
    check("R2", "vd held", int'(out_vd), int'(held_vd));

    // R3, R9: all function-field pairs, plus a wrong major opcode
    for (int f6 = 0; f6 < 64; f6++) begin
      for (int f3 = 0; f3 < 8; f3++) begin
        apply(enc(f6, 1, 4, 8, f3, 12), 1, 2);
      end
    end
    apply(enc(0, 1, 8, 8, 1, 8) ^ 32'h1, 1, 0);
    apply(enc(2, 1, 8, 8, 5, 8) ^ 32'h40, 1, 0);

    // R4..R8: sweep configuration, mask, destination and source pairs
    for (int form = 0; form < 5; form++) begin
      for (int ew = 0; ew < 4; ew++) begin
        for (int g = 0; g < 4; g++) begin
          for (int vm = 0; vm < 2; vm++) begin
            for (int vd = 0; vd < 32; vd++) begin
              for (int k = 0; k < 8; k++) begin
                int f6, f3;
                f6 = (form == 4) ? 39 : ((form % 2) == 0 ? 0 : 2);
                f3 = (form < 2) ? 1 : 5;
                apply(enc(f6, vm, pair_vs2(k), pair_s1(k), f3, vd), ew, g);
              end
            end
          end
        end
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule